// File: doc/BRIEF.md
# Header-Check Cell Lock Tracker

This block decides whether a receiver has found the boundaries of fixed-length cells in an incoming stream. An upstream stage presents one strobe per candidate cell, along with a flag that says whether the header check of that cell was correct. The tracker counts runs of good or bad header checks and raises or drops a single lock status bit.

When the tracker is hunting, a run of good checks of programmable length gains lock. When it is locked, a run of bad checks of another programmable length loses lock. Both run lengths are 4-bit fields in one 8-bit read/write configuration register. That register has a nonzero reset default, so the tracker works without any setup by software.

Cycles where the strobe is low are idle and change nothing. Idle cycles do not break a run.

Top module: `cell_lock_tracker`

## Requirements
- R1: After reset, `locked` is 0, both run counts are zero, and `cfg_rd_data` reads 0x78. That value means a lose-lock run of 7 and a gain-lock run of 8.
- R2: A cycle with `cfg_wr_en` high loads `cfg_wr_data` into the configuration register, and it reads back on `cfg_rd_data` from the next cycle on. Bits [7:4] hold the lose-lock run length and bits [3:0] hold the gain-lock run length.
- R3: While hunting, `locked` rises after the gain-lock number of consecutive cells with `hdr_ok` = 1.
- R4: While hunting, a cell with `hdr_ok` = 0 restarts the good-check run from zero.
- R5: While locked, `locked` falls after the lose-lock number of consecutive cells with `hdr_ok` = 0.
- R6: While locked, a cell with `hdr_ok` = 1 restarts the bad-check run from zero.
- R7: A change of `locked` is registered on the clock edge that samples the cell completing the run, so it is visible one cycle after the strobe. The run for the new state then starts from zero.
- R8: A run-length field of 0 behaves as 1, so a single qualifying cell changes the state.
- R9: A configuration write leaves the lock state and the run in progress untouched. A cell presented in the same cycle as the write is judged against the old value. Cells after the write are judged against the new value.
- R10: In a cycle with `cell_valid` = 0, `hdr_ok` is ignored and neither the lock state nor any run count changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the threshold register |
| cfg_wr_data | input | 8 | Write data: [7:4] lose-lock run, [3:0] gain-lock run |
| cfg_rd_data | output | 8 | Current threshold register value |
| cell_valid | input | 1 | One-cycle strobe per received cell |
| hdr_ok | input | 1 | Header check result of the strobed cell (1 = correct) |
| locked | output | 1 | Cell delineation lock status |

## Verification
Both results are registered exactly once. `locked` reflects a strobed cell one cycle after that strobe, and `cfg_rd_data` reflects a write one cycle after the write strobe.

The bench drives inputs just after a rising edge and lets them be consumed at the following edge. It compares against its reference model on every falling edge, after both have absorbed the same edge. The directed checks are taken immediately after the consuming edge, so the expected value is always the one due one cycle after the stimulus.

// File: rtl/cell_lock_pkg.sv
package cell_lock_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } lock_state_e;

    // run-counter slot indices inside the generate array
    localparam int SLOT_GAIN = 0;
    localparam int SLOT_LOSE = 1;
    localparam int NUM_SLOTS = 2;

endpackage

// File: rtl/lock_cfg_reg.sv
module lock_cfg_reg #(
    parameter int          THR_W   = 4,
    parameter logic [7:0]  RST_VAL = 8'h78
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2*THR_W-1:0]   wr_data,
    output logic [2*THR_W-1:0]   rd_data,
    output logic [THR_W-1:0]     lose_limit,
    output logic [THR_W-1:0]     gain_limit
);
    localparam int CFG_W = 2 * THR_W;

    typedef struct packed {
        logic [CFG_W-1:0] val;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [THR_W-1:0] lose_raw, gain_raw;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.val = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.val <= CFG_W'(RST_VAL);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lose_raw   = cfg_q.val[CFG_W-1:THR_W];
    assign gain_raw   = cfg_q.val[THR_W-1:0];
    // a zero field acts as a run of one
    assign lose_limit = (lose_raw == '0) ? THR_W'(1) : lose_raw;
    assign gain_limit = (gain_raw == '0) ? THR_W'(1) : gain_raw;
    assign rd_data    = cfg_q.val;

endmodule

// File: rtl/run_counter.sv
module run_counter #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             strobe,
    input  logic             match,
    input  logic [THR_W-1:0] limit,
    output logic             done
);
    typedef struct packed {
        logic [THR_W-1:0] cnt;
    } run_t;

    run_t run_d, run_q;
    logic [THR_W:0] next_len;

    assign next_len = {1'b0, run_q.cnt} + (THR_W+1)'(1);

    always_comb begin
        run_d = run_q;
        done  = 1'b0;
        if (!active) begin
            run_d.cnt = '0;
        end else if (strobe) begin
            if (match) begin
                if (next_len >= {1'b0, limit}) begin
                    done      = 1'b1;
                    run_d.cnt = '0;
                end else begin
                    run_d.cnt = next_len[THR_W-1:0];
                end
            end else begin
                run_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q.cnt <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import cell_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gain_done,
    input  logic lose_done,
    output logic in_lock,
    output logic in_hunt
);
    typedef struct packed {
        lock_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_HUNT: if (gain_done) fsm_d.st = ST_LOCK;
            ST_LOCK: if (lose_done) fsm_d.st = ST_HUNT;
            default: fsm_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st <= ST_HUNT;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign in_lock = (fsm_q.st == ST_LOCK);
    assign in_hunt = (fsm_q.st == ST_HUNT);

endmodule

// File: rtl/cell_lock_tracker.sv
module cell_lock_tracker
    import cell_lock_pkg::*;
#(
    parameter int         THR_W   = 4,
    parameter logic [7:0] RST_VAL = 8'h78
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [2*THR_W-1:0] cfg_wr_data,
    output logic [2*THR_W-1:0] cfg_rd_data,
    input  logic               cell_valid,
    input  logic               hdr_ok,
    output logic               locked
);
    logic [THR_W-1:0] lose_limit, gain_limit;
    logic             in_lock, in_hunt;
    logic [NUM_SLOTS-1:0] slot_active, slot_match, slot_done;
    logic [THR_W-1:0]     slot_limit [NUM_SLOTS];

    lock_cfg_reg #(
        .THR_W   (THR_W),
        .RST_VAL (RST_VAL)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .rd_data    (cfg_rd_data),
        .lose_limit (lose_limit),
        .gain_limit (gain_limit)
    );

    // one run counter per direction: good checks while hunting, bad while locked
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_run
        if (g == SLOT_GAIN) begin : g_gain
            assign slot_active[g] = in_hunt;
            assign slot_match[g]  = hdr_ok;
            assign slot_limit[g]  = gain_limit;
        end else begin : g_lose
            assign slot_active[g] = in_lock;
            assign slot_match[g]  = ~hdr_ok;
            assign slot_limit[g]  = lose_limit;
        end

        run_counter #(
            .THR_W (THR_W)
        ) u_run (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (slot_active[g]),
            .strobe (cell_valid),
            .match  (slot_match[g]),
            .limit  (slot_limit[g]),
            .done   (slot_done[g])
        );
    end

    lock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gain_done (slot_done[SLOT_GAIN]),
        .lose_done (slot_done[SLOT_LOSE]),
        .in_lock   (in_lock),
        .in_hunt   (in_hunt)
    );

    assign locked = in_lock;

endmodule

// File: rtl/cell_lock_chk.sv
module cell_lock_chk #(
    parameter int THR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr_en,
    input logic [2*THR_W-1:0] cfg_wr_data,
    input logic [2*THR_W-1:0] cfg_rd_data,
    input logic               cell_valid,
    input logic               hdr_ok,
    input logic               locked
);
    // R2
    wr_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_rd_data));

    // R3
    rise_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cell_valid && hdr_ok));

    // R5
    fall_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(cell_valid && !hdr_ok));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_valid |=> $stable(locked));

    // R8
    gain_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && cell_valid && hdr_ok && cfg_rd_data[THR_W-1:0] <= 1) |=> locked);

    // R8
    lose_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cell_valid && !hdr_ok && cfg_rd_data[2*THR_W-1:THR_W] <= 1) |=> !locked);

endmodule

bind cell_lock_tracker cell_lock_chk #(.THR_W(THR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .cell_valid  (cell_valid),
    .hdr_ok      (hdr_ok),
    .locked      (locked)
);

// File: tb/cell_lock_tracker_tb.sv
`timescale 1ns/1ps
module cell_lock_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       cell_valid = 1'b0;
    logic       hdr_ok = 1'b0;
    logic       locked;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    // reference model state
    int       m_good = 0;
    int       m_bad  = 0;
    bit       m_lock = 0;
    bit [7:0] m_cfg  = 8'h78;

    always #2.5 clk = ~clk;

    cell_lock_tracker u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .cell_valid  (cell_valid),
        .hdr_ok      (hdr_ok),
        .locked      (locked)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_good = 0; m_bad = 0; m_lock = 0; m_cfg = 8'h78;
        end else begin
            int lose_n, gain_n;
            lose_n = (m_cfg[7:4] == 0) ? 1 : int'(m_cfg[7:4]);
            gain_n = (m_cfg[3:0] == 0) ? 1 : int'(m_cfg[3:0]);
            if (cell_valid) begin
                if (!m_lock) begin
                    if (hdr_ok) begin
                        m_good++;
                        if (m_good >= gain_n) begin m_lock = 1; m_good = 0; end
                    end else m_good = 0;
                end else begin
                    if (!hdr_ok) begin
                        m_bad++;
                        if (m_bad >= lose_n) begin m_lock = 0; m_bad = 0; end
                    end else m_bad = 0;
                end
            end
            if (cfg_wr_en) m_cfg = cfg_wr_data;
        end
    end

    // model comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (locked !== m_lock || cfg_rd_data !== m_cfg) begin
                n_fail++;
                $display("FAIL %s model: locked=%0b cfg=%02h expected locked=%0b cfg=%02h",
                         cur_req, locked, cfg_rd_data, m_lock, m_cfg);
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s directed: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // inputs driven just after a rising edge, consumed at the next one
    task automatic step(input bit v, input bit ok, input bit we, input logic [7:0] wd);
        cell_valid = v; hdr_ok = ok; cfg_wr_en = we; cfg_wr_data = wd;
        @(posedge clk); #1;
        cell_valid = 1'b0; hdr_ok = 1'b0; cfg_wr_en = 1'b0;
    endtask

    task automatic cells(input int n, input bit ok);
        for (int i = 0; i < n; i++) step(1'b1, ok, 1'b0, 8'h00);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check({7'd0, locked}, 8'h00, "R1");
        check(cfg_rd_data, 8'h78, "R1");

        // R3 gain after 8 good cells
        cur_req = "R3";
        cells(7, 1'b1);
        check({7'd0, locked}, 8'h00, "R3");
        cells(1, 1'b1);
        check({7'd0, locked}, 8'h01, "R3");

        // R5 and R7: lose after 7 bad cells, run starts fresh after lock
        cur_req = "R5";
        cells(6, 1'b0);
        check({7'd0, locked}, 8'h01, "R5");
        cells(1, 1'b0);
        check({7'd0, locked}, 8'h00, "R5");

        // R4 bad cell restarts good run
        cur_req = "R4";
        cells(5, 1'b1); cells(1, 1'b0); cells(7, 1'b1);
        check({7'd0, locked}, 8'h00, "R4");
        cells(1, 1'b1);
        check({7'd0, locked}, 8'h01, "R4");

        // R6 good cell restarts bad run
        cur_req = "R6";
        cells(6, 1'b0); cells(1, 1'b1); cells(6, 1'b0);
        check({7'd0, locked}, 8'h01, "R6");
        cells(1, 1'b0);
        check({7'd0, locked}, 8'h00, "R6");

        // R2 write and readback
        cur_req = "R2";
        step(1'b0, 1'b0, 1'b1, 8'h23);
        check(cfg_rd_data, 8'h23, "R2");
        cells(2, 1'b1);
        check({7'd0, locked}, 8'h00, "R2");
        cells(1, 1'b1);
        check({7'd0, locked}, 8'h01, "R2");

        // R7 new bad run starts from zero after lock (alpha=2)
        cur_req = "R7";
        cells(1, 1'b0);
        check({7'd0, locked}, 8'h01, "R7");
        cells(1, 1'b0);
        check({7'd0, locked}, 8'h00, "R7");

        // R9 write keeps the run in progress; same-cycle cell uses old value
        cur_req = "R9";
        step(1'b0, 1'b0, 1'b1, 8'h28);
        cells(2, 1'b1);
        step(1'b1, 1'b1, 1'b1, 8'h23);   // third good judged against delta 8
        check({7'd0, locked}, 8'h00, "R9");
        cells(1, 1'b1);                  // fourth good, delta now 3
        check({7'd0, locked}, 8'h01, "R9");

        // R8 zero fields behave as one
        cur_req = "R8";
        step(1'b0, 1'b0, 1'b1, 8'h00);
        cells(1, 1'b0);
        check({7'd0, locked}, 8'h00, "R8");
        cells(1, 1'b1);
        check({7'd0, locked}, 8'h01, "R8");

        // R10 idle cycles ignore hdr_ok and do not break a run
        cur_req = "R10";
        step(1'b0, 1'b0, 1'b1, 8'h33);
        cells(2, 1'b0);
        check({7'd0, locked}, 8'h01, "R10");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
        check({7'd0, locked}, 8'h01, "R10");
        cells(1, 1'b0);
        check({7'd0, locked}, 8'h00, "R10");
        cells(1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
        cells(1, 1'b1);
        check({7'd0, locked}, 8'h00, "R10");
        cells(1, 1'b1);
        check({7'd0, locked}, 8'h01, "R10");

        // mixed random traffic against the model
        cur_req = "R3/R5 random";
        for (int i = 0; i < 3000; i++) begin
            bit v, ok, we;
            logic [7:0] wd;
            v  = ($urandom % 4) != 0;
            ok = ($urandom % 3) != 0;
            we = ($urandom % 97) == 0;
            wd = 8'($urandom);
            step(v, ok, we, wd);
        end

        @(negedge clk);
        finish_run();
    end

endmodule